// File: doc/BRIEF.md
# Debug exception entry controller

This block sits beside a processor pipeline and performs the state update that accompanies entry into debug mode. When the pipeline raises a debug request and the core is not already in debug mode, the controller stores the restart address. This is the current PC, or the PC of the branch or jump when the excepting instruction occupies a delay slot. It also records the cause in a set of eight event flags, takes a snapshot of the halt and doze status, and raises the debug-mode and imprecise-exception-inhibit flags. In the same edge it issues a one-cycle fetch redirect toward the debug vector.

A probe-trap configuration bit chooses between two vector locations. While in debug mode, a strobe reporting an exception raised inside the handler wipes the event flags, so the handler can tell such an exception apart from a genuine debug event. A return strobe leaves debug mode. Every update is registered on the clock edge that samples the request.

Top module: `dbg_entry_ctrl`

## Requirements
- R1: An accepted request with `in_dslot_i`=1 loads `restart_pc_o` with `br_pc_i` and sets `dslot_o` to 1 on the same clock edge.
- R2: An accepted request with `in_dslot_i`=0 loads `restart_pc_o` with `cur_pc_i` and clears `dslot_o` to 0.
- R3: On an accepted request, `evt_o` is loaded from `evt_type_i`, with bit positions 0 single step, 1 breakpoint instruction, 2 data break load, 3 data break store, 4 instruction break, 5 debug interrupt, 6 imprecise data break load, 7 imprecise data break store; an all-zero type records all zeros.
- R4: On an accepted request, `halt_o` and `doze_o` take the values of `halt_i` and `doze_i` sampled at that edge.
- R5: On an accepted request, `dm_o` and `iexi_o` become 1.
- R6: An accepted request makes `redirect_o` high for exactly the following cycle, with `redirect_pc_o` = 32'hBFC00480 if `probe_trap_i` was 0 and 32'hFF200200 if it was 1.
- R7: `exc_in_dm_i` while `dm_o`=1 clears all eight event flags and leaves `restart_pc_o`, `dslot_o` and `dm_o` unchanged; while `dm_o`=0 it has no effect.
- R8: A request while `dm_o`=1 is ignored: no redirect, and restart PC, delay-slot flag, event flags, halt and doze are unchanged.
- R9: `dret_i` while `dm_o`=1 clears `dm_o` and `iexi_o`.
- R10: Reset (`rst_ni`=0) clears debug mode, the inhibit flag, the delay-slot flag, all event flags, halt, doze, the restart PC and the redirect pulse.
- R11: If several type bits are set, only the lowest-numbered one is recorded in `evt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_req_i | input | 1 | Debug exception request |
| cur_pc_i | input | 32 | PC of the excepting instruction |
| br_pc_i | input | 32 | PC of the branch or jump owning the delay slot |
| in_dslot_i | input | 1 | Excepting instruction is in a delay slot |
| evt_type_i | input | 8 | Debug event type, one-hot expected |
| halt_i | input | 1 | Halt status at the exception |
| doze_i | input | 1 | Doze status at the exception |
| probe_trap_i | input | 1 | Selects the probe-side vector |
| exc_in_dm_i | input | 1 | Exception raised inside debug mode |
| dret_i | input | 1 | Return from debug mode |
| restart_pc_o | output | 32 | Restart address |
| dslot_o | output | 1 | Last entry came from a delay slot |
| evt_o | output | 8 | Event flags |
| halt_o | output | 1 | Saved halt status |
| doze_o | output | 1 | Saved doze status |
| iexi_o | output | 1 | Imprecise-exception inhibit |
| dm_o | output | 1 | Debug mode |
| redirect_o | output | 1 | One-cycle fetch redirect request |
| redirect_pc_o | output | 32 | Redirect target |

## Verification
The assertions take for granted that the pipeline never raises a request and a return strobe in a state where a return would be meaningless, and that the event type reaching an accepted request is at most loosely one-hot. The lowest-bit property depends only on bit 0 of the type. The stimulus drives every input on the falling edge, holds each request for a single cycle and follows each entry with a return strobe before the next entry. Multi-bit and all-zero types are applied only where the priority rule or R3 is under test.

// File: rtl/dbg_entry_pkg.sv
package dbg_entry_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned NUM_EVT = 8;

  typedef enum logic [2:0] {
    EVT_SSTEP   = 3'd0,
    EVT_BRK     = 3'd1,
    EVT_DLOAD   = 3'd2,
    EVT_DSTORE  = 3'd3,
    EVT_IBRK    = 3'd4,
    EVT_DINT    = 3'd5,
    EVT_DLOAD_I = 3'd6,
    EVT_DSTOR_I = 3'd7
  } evt_idx_e;

  localparam logic [XLEN-1:0] VEC_NORMAL = 32'hBFC0_0480;
  localparam logic [XLEN-1:0] VEC_PROBE  = 32'hFF20_0200;
endpackage

// File: rtl/dbg_evt_prio.sv
module dbg_evt_prio #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  // lowest index wins
  for (genvar g = 0; g < N; g++) begin : g_prio
    assign sel_o[g]    = req_i[g] & ~seen[g];
    assign seen[g+1]   = seen[g] | req_i[g];
  end
endmodule

// File: rtl/dbg_restart_capture.sv
module dbg_restart_capture #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            dslot_i,
  input  logic [XLEN-1:0] cur_pc_i,
  input  logic [XLEN-1:0] br_pc_i,
  output logic [XLEN-1:0] restart_pc_o,
  output logic            dslot_o
);
  logic [XLEN-1:0] pc_q;
  logic            ds_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ds_q <= 1'b0;
    end else if (take_i) begin
      pc_q <= dslot_i ? br_pc_i : cur_pc_i;
      ds_q <= dslot_i;
    end
  end

  assign restart_pc_o = pc_q;
  assign dslot_o      = ds_q;

  assert_dslot_pc_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && dslot_i |=> restart_pc_o == $past(br_pc_i) && dslot_o);

  assert_plain_pc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !dslot_i |=> restart_pc_o == $past(cur_pc_i) && !dslot_o);

  assert_hold_pc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(restart_pc_o) && $stable(dslot_o));
endmodule

// File: rtl/dbg_vector_sel.sv
module dbg_vector_sel #(
  parameter int unsigned     XLEN       = 32,
  parameter logic [XLEN-1:0] VEC_NORMAL = '0,
  parameter logic [XLEN-1:0] VEC_PROBE  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            probe_trap_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] target_o
);
  logic            pulse_q;
  logic [XLEN-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      tgt_q   <= VEC_NORMAL;
    end else begin
      pulse_q <= take_i;
      if (take_i) tgt_q <= probe_trap_i ? VEC_PROBE : VEC_NORMAL;
    end
  end

  assign redirect_o = pulse_q;
  assign target_o   = tgt_q;

  assert_vec_normal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !probe_trap_i |=> redirect_o && target_o == VEC_NORMAL);

  assert_vec_probe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && probe_trap_i |=> redirect_o && target_o == VEC_PROBE);

  assert_no_spurious_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> !redirect_o);
endmodule

// File: rtl/dbg_entry_ctrl.sv
module dbg_entry_ctrl
  import dbg_entry_pkg::*;
#(
  parameter int unsigned     PC_W    = XLEN,
  parameter int unsigned     EVT_W   = NUM_EVT,
  parameter logic [PC_W-1:0] VEC_NRM = VEC_NORMAL,
  parameter logic [PC_W-1:0] VEC_PRB = VEC_PROBE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dbg_req_i,
  input  logic [PC_W-1:0]  cur_pc_i,
  input  logic [PC_W-1:0]  br_pc_i,
  input  logic             in_dslot_i,
  input  logic [EVT_W-1:0] evt_type_i,
  input  logic             halt_i,
  input  logic             doze_i,
  input  logic             probe_trap_i,
  input  logic             exc_in_dm_i,
  input  logic             dret_i,
  output logic [PC_W-1:0]  restart_pc_o,
  output logic             dslot_o,
  output logic [EVT_W-1:0] evt_o,
  output logic             halt_o,
  output logic             doze_o,
  output logic             iexi_o,
  output logic             dm_o,
  output logic             redirect_o,
  output logic [PC_W-1:0]  redirect_pc_o
);
  logic             dm_q, iexi_q, halt_q, doze_q;
  logic [EVT_W-1:0] evt_q, evt_sel;
  logic             take;

  assign take = dbg_req_i & ~dm_q;

  dbg_evt_prio #(.N(EVT_W)) u_prio (
    .req_i (evt_type_i),
    .sel_o (evt_sel)
  );

  dbg_restart_capture #(.XLEN(PC_W)) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .dslot_i      (in_dslot_i),
    .cur_pc_i     (cur_pc_i),
    .br_pc_i      (br_pc_i),
    .restart_pc_o (restart_pc_o),
    .dslot_o      (dslot_o)
  );

  dbg_vector_sel #(.XLEN(PC_W), .VEC_NORMAL(VEC_NRM), .VEC_PROBE(VEC_PRB)) u_vec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (take),
    .probe_trap_i (probe_trap_i),
    .redirect_o   (redirect_o),
    .target_o     (redirect_pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dm_q   <= 1'b0;
      iexi_q <= 1'b0;
      halt_q <= 1'b0;
      doze_q <= 1'b0;
      evt_q  <= '0;
    end else if (take) begin
      dm_q   <= 1'b1;
      iexi_q <= 1'b1;
      halt_q <= halt_i;
      doze_q <= doze_i;
      evt_q  <= evt_sel;
    end else if (dm_q) begin
      if (exc_in_dm_i) evt_q <= '0;
      if (dret_i) begin
        dm_q   <= 1'b0;
        iexi_q <= 1'b0;
      end
    end
  end

  assign dm_o   = dm_q;
  assign iexi_o = iexi_q;
  assign halt_o = halt_q;
  assign doze_o = doze_q;
  assign evt_o  = evt_q;

  assert_evt_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> $onehot0(evt_o));

  assert_status_copy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> halt_o == $past(halt_i) && doze_o == $past(doze_i));

  assert_enter_dm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |=> dm_o && iexi_o);

  assert_dm_exc_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_o && exc_in_dm_i && !dbg_req_i |=> evt_o == '0);

  assert_req_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_o && dbg_req_i |=> !redirect_o && $stable(halt_o) && $stable(doze_o));

  assert_dret_exit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dm_o && dret_i |=> !dm_o && !iexi_o);

  assert_lowest_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && evt_type_i[0] |=> evt_o == EVT_W'(1));
endmodule

// File: tb/dbg_entry_ctrl_bench.sv
module dbg_entry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] V_NRM = 32'hBFC0_0480;
  localparam logic [31:0] V_PRB = 32'hFF20_0200;

  typedef struct packed {
    logic        ds;
    logic [31:0] cpc;
    logic [31:0] bpc;
    logic [7:0]  evt;
    logic [7:0]  exp_evt;
    logic        hlt;
    logic        dz;
    logic        pt;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h8000_1000, 32'h8000_0FFC, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h8000_2004, 32'h8000_2000, 8'h02, 8'h02, 1'b1, 1'b0, 1'b1},
    '{1'b0, 32'h9000_0040, 32'h1234_5678, 8'h80, 8'h80, 1'b0, 1'b1, 1'b1},
    '{1'b1, 32'hA000_0010, 32'hA000_000C, 8'h30, 8'h10, 1'b1, 1'b1, 1'b0},
    '{1'b0, 32'hFFFF_FFFC, 32'h0000_0000, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
    '{1'b1, 32'h0000_0004, 32'h0000_0000, 8'hFF, 8'h01, 1'b1, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, ds = 1'b0, hlt = 1'b0, dz = 1'b0, pt = 1'b0;
  logic        exc = 1'b0, dret = 1'b0;
  logic [31:0] cpc = '0, bpc = '0;
  logic [7:0]  evt = '0;
  logic [31:0] rpc, vpc;
  logic        dslot, hlt_o, dz_o, iexi, dm, redir;
  logic [7:0]  evt_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_entry_ctrl u_dbg_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dbg_req_i(req), .cur_pc_i(cpc), .br_pc_i(bpc),
    .in_dslot_i(ds), .evt_type_i(evt), .halt_i(hlt), .doze_i(dz),
    .probe_trap_i(pt), .exc_in_dm_i(exc), .dret_i(dret),
    .restart_pc_o(rpc), .dslot_o(dslot), .evt_o(evt_o), .halt_o(hlt_o),
    .doze_o(dz_o), .iexi_o(iexi), .dm_o(dm), .redirect_o(redir),
    .redirect_pc_o(vpc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic leave_dm();
    dret = 1'b1;
    tick();
    dret = 1'b0;
    check("R9 dm cleared", 32'(dm), 32'd0);
    check("R9 iexi cleared", 32'(iexi), 32'd0);
  endtask

  task automatic check_reset();
    check("R10 dm", 32'(dm), 0);
    check("R10 iexi", 32'(iexi), 0);
    check("R10 dslot", 32'(dslot), 0);
    check("R10 evt", 32'(evt_o), 0);
    check("R10 halt/doze", {30'd0, hlt_o, dz_o}, 0);
    check("R10 restart pc", rpc, 0);
    check("R10 redirect", 32'(redir), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      ds = v.ds; cpc = v.cpc; bpc = v.bpc; evt = v.evt;
      hlt = v.hlt; dz = v.dz; pt = v.pt; req = 1'b1;
      tick();
      req = 1'b0;
      check(v.ds ? "R1 restart pc" : "R2 restart pc", rpc, v.ds ? v.bpc : v.cpc);
      check(v.ds ? "R1 dslot" : "R2 dslot", 32'(dslot), 32'(v.ds));
      check((v.evt == v.exp_evt) ? "R3 events" : "R11 lowest event", 32'(evt_o), 32'(v.exp_evt));
      check("R4 halt/doze", {30'd0, hlt_o, dz_o}, {30'd0, v.hlt, v.dz});
      check("R5 dm/iexi", {30'd0, dm, iexi}, 32'd3);
      check("R6 redirect pulse", 32'(redir), 32'd1);
      check("R6 vector", vpc, v.pt ? V_PRB : V_NRM);
      tick();
      check("R6 pulse one cycle", 32'(redir), 32'd0);
      leave_dm();
    end

    // R8: request while in debug mode
    ds = 1'b0; cpc = 32'h0000_1000; evt = 8'h20; hlt = 1'b0; dz = 1'b0; pt = 1'b0; req = 1'b1;
    tick();
    req = 1'b0;
    check("R3 debug interrupt bit", 32'(evt_o), 32'h20);
    tick();
    ds = 1'b1; bpc = 32'h0000_2222; cpc = 32'h0000_3333; evt = 8'h04; hlt = 1'b1; dz = 1'b1; pt = 1'b1; req = 1'b1;
    tick();
    req = 1'b0;
    check("R8 no redirect", 32'(redir), 0);
    check("R8 restart pc held", rpc, 32'h0000_1000);
    check("R8 dslot held", 32'(dslot), 0);
    check("R8 events held", 32'(evt_o), 32'h20);
    check("R8 halt/doze held", {30'd0, hlt_o, dz_o}, 0);

    // R7: exception inside debug mode
    exc = 1'b1;
    tick();
    exc = 1'b0;
    check("R7 events cleared", 32'(evt_o), 0);
    check("R7 restart pc kept", rpc, 32'h0000_1000);
    check("R7 dm kept", 32'(dm), 1);
    leave_dm();

    // R7: strobe outside debug mode has no effect
    ds = 1'b0; cpc = 32'h0000_4444; evt = 8'h08; req = 1'b1;
    tick();
    req = 1'b0;
    leave_dm();
    exc = 1'b1;
    tick();
    exc = 1'b0;
    check("R7 no effect outside dm", 32'(evt_o), 32'h08);

    // R10: reset mid-run after entry
    cpc = 32'h0000_5555; evt = 8'h40; hlt = 1'b1; req = 1'b1;
    tick();
    req = 1'b0;
    rst_n = 1'b0;
    #1;
    check_reset();
    tick();
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule